// File: doc/BRIEF.md
# Streaming Tournament Sorter with Run Coloring

The block sorts a stream of keys with a loser tree that is held in two small memories. One memory holds the leaves: each leaf has a key, the row pointer that came with it, and a run color. The other memory holds one entry per internal node, and that entry points at the leaf that lost the comparison at that node. A register keeps the index of the overall winner. Each key that comes in is written into the leaf of the winner that was emitted last. The key then climbs to the root one level per cycle through a single shared comparator. At each level it swaps with the stored loser when the stored loser is smaller.

Keys smaller than the last emitted key cannot join the current sorted run. They are tagged with the other color, and any key of the current color beats any key of the other color. Such keys stay in the tree and wait for the next run, so the tree is never flushed. The output stream carries the key, its pointer, and a flag on the first word of each run. The producer marks its final key. The block then replaces every vacated leaf with a maximum sentinel of a terminal class, emits everything that is still stored, and raises `done`. `done` stays high until the next reset.

Top module: `tourney_sorter`

## Requirements
- R1: After reset, `out_valid` and `done` are low and `in_ready` is high.
- R2: No output word is offered until LEAVES keys have been accepted, unless a key marked with `in_last` was accepted earlier.
- R3: Output order is replacement selection. Each emitted word is the smallest stored entry, ranked first by run and then by key. Keys inside one run never decrease, and every key leaves with the pointer it entered with.
- R4: An incoming key strictly smaller than the last emitted key is assigned to the next run, and any other key stays in the current run. `out_first` is high on the very first output word and on the first word of every later run, and low on all other words.
- R5: Every run that is followed by another run contains at least LEAVES words.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_key`, `out_ptr` and `out_first` hold their values.
- R7: Once the key flagged with `in_last` has been accepted, `in_ready` stays low. All stored keys are then emitted in order, no sentinel ever appears at the output, and `done` rises and stays high while `out_valid` stays low.
- R8: Every accepted key is emitted exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Block can take an input word this cycle |
| in_key | input | KEY_W | Sort key, unsigned |
| in_ptr | input | PTR_W | Row pointer carried with the key |
| in_last | input | 1 | Marks the final key of the stream |
| out_valid | output | 1 | Output word offered |
| out_ready | input | 1 | Consumer accepts the output word |
| out_key | output | KEY_W | Emitted key |
| out_ptr | output | PTR_W | Pointer of the emitted key |
| out_first | output | 1 | Word is the first of a sorted run |
| done | output | 1 | All keys emitted after end of input |

## Verification
The assertions check these properties on every cycle:
- output words are held under backpressure;
- keys do not decrease between run boundaries;
- no word is offered during the initial fill;
- every completed run reaches LEAVES words;
- input stays closed after the end marker;
- `done` is sticky.

Whether each word is the correct one is a different matter. That means the exact interleaving of runs, the pairing of keys with pointers, the placement of run flags, and the absence of sentinels or lost keys. Only the bench's scenarios can show this, by comparing against a reference replacement-selection model. The scenarios use scattered keys, strictly falling keys, rising keys, a sawtooth pattern and a stream shorter than the tree, with irregular backpressure on the output.

// File: rtl/tourney_sorter.sv
module tourney_sorter #(
  parameter int LEAVES = 16,
  parameter int KEY_W  = 16,
  parameter int PTR_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [KEY_W-1:0] in_key,
  input  logic [PTR_W-1:0] in_ptr,
  input  logic             in_last,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [KEY_W-1:0] out_key,
  output logic [PTR_W-1:0] out_ptr,
  output logic             out_first,
  output logic             done
);

  localparam int IW = $clog2(LEAVES);
  localparam int RW = 2 + KEY_W + IW;
  localparam logic [1:0] CL_VOID = 2'd0;
  localparam logic [1:0] CL_CUR  = 2'd1;
  localparam logic [1:0] CL_NEXT = 2'd2;
  localparam logic [1:0] CL_SENT = 2'd3;

  logic [KEY_W-1:0] leaf_key  [LEAVES];
  logic [PTR_W-1:0] leaf_ptr  [LEAVES];
  logic             leaf_void [LEAVES];
  logic             leaf_sent [LEAVES];
  logic             leaf_col  [LEAVES];
  logic [IW-1:0]    loser     [LEAVES];

  logic [IW-1:0]    win_idx, cand, node;
  logic             vacant, climbing, ended, have_out, cur_color;
  logic [KEY_W-1:0] last_key;

  function automatic logic [1:0] class_of(input logic v, input logic s, input logic c, input logic cur);
    if (v)             return CL_VOID;
    else if (s)        return CL_SENT;
    else if (c == cur) return CL_CUR;
    else               return CL_NEXT;
  endfunction

  function automatic logic [IW-1:0] first_right_leaf(input int i);
    int r;
    r = 2 * i + 1;
    for (int j = 0; j < IW; j++)
      if (r < LEAVES) r = r * 2;
    return IW'(r - LEAVES);
  endfunction

  logic [1:0]    win_cls;
  logic [IW-1:0] lo;
  logic [RW-1:0] rank_cand, rank_lo;
  logic          lo_wins;
  logic [IW-1:0] step_win;
  logic          open_slot, ins_ext, ins_sent, insert, out_fire, new_col;

  assign win_cls   = class_of(leaf_void[win_idx], leaf_sent[win_idx], leaf_col[win_idx], cur_color);
  assign lo        = loser[node];
  assign rank_cand = {class_of(leaf_void[cand], leaf_sent[cand], leaf_col[cand], cur_color), leaf_key[cand], cand};
  assign rank_lo   = {class_of(leaf_void[lo], leaf_sent[lo], leaf_col[lo], cur_color), leaf_key[lo], lo};
  assign lo_wins   = rank_lo < rank_cand;
  assign step_win  = lo_wins ? lo : cand;

  assign open_slot = !climbing && (vacant || win_cls == CL_VOID);
  assign in_ready  = open_slot && !ended;
  assign ins_ext   = in_valid && in_ready;
  assign ins_sent  = open_slot && ended;
  assign insert    = ins_ext || ins_sent;
  assign new_col   = (have_out && in_key < last_key) ? ~cur_color : cur_color;

  assign out_valid = !climbing && !vacant && (win_cls == CL_CUR || win_cls == CL_NEXT);
  assign out_fire  = out_valid && out_ready;
  assign out_key   = leaf_key[win_idx];
  assign out_ptr   = leaf_ptr[win_idx];
  assign out_first = !have_out || (leaf_col[win_idx] != cur_color);
  assign done      = ended && !climbing && !vacant && win_cls == CL_SENT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LEAVES; i++) begin
        leaf_key[i]  <= '0;
        leaf_ptr[i]  <= '0;
        leaf_void[i] <= 1'b1;
        leaf_sent[i] <= 1'b0;
        leaf_col[i]  <= 1'b0;
        loser[i]     <= (i == 0) ? '0 : first_right_leaf(i);
      end
      win_idx   <= '0;
      cand      <= '0;
      node      <= '0;
      vacant    <= 1'b0;
      climbing  <= 1'b0;
      ended     <= 1'b0;
      have_out  <= 1'b0;
      cur_color <= 1'b0;
      last_key  <= '0;
    end else if (insert) begin
      leaf_key[win_idx]  <= ins_ext ? in_key : '1;
      leaf_ptr[win_idx]  <= ins_ext ? in_ptr : '0;
      leaf_void[win_idx] <= 1'b0;
      leaf_sent[win_idx] <= !ins_ext;
      leaf_col[win_idx]  <= ins_ext ? new_col : cur_color;
      cand     <= win_idx;
      node     <= {1'b1, win_idx[IW-1:1]};
      climbing <= 1'b1;
      vacant   <= 1'b0;
      if (ins_ext && in_last) ended <= 1'b1;
    end else if (climbing) begin
      if (lo_wins) loser[node] <= cand;
      if (node == IW'(1)) begin
        climbing <= 1'b0;
        win_idx  <= step_win;
      end else begin
        node <= node >> 1;
        cand <= step_win;
      end
    end else if (out_fire) begin
      vacant    <= 1'b1;
      last_key  <= leaf_key[win_idx];
      cur_color <= leaf_col[win_idx];
      have_out  <= 1'b1;
    end
  end

  logic [IW:0] fill_cnt, run_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_cnt <= '0;
      run_len  <= '0;
    end else begin
      if (ins_ext && fill_cnt < (IW+1)'(LEAVES)) fill_cnt <= fill_cnt + 1'b1;
      if (out_fire) begin
        if (out_first) run_len <= (IW+1)'(1);
        else if (run_len < (IW+1)'(LEAVES)) run_len <= run_len + 1'b1;
      end
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_key) && $stable(out_ptr) && $stable(out_first)); // R6
  AST_RUN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_first |-> out_key >= last_key); // R3
  AST_FILL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ended && fill_cnt < (IW+1)'(LEAVES) |-> !out_valid); // R2
  AST_MIN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire && out_first && have_out |-> run_len >= (IW+1)'(LEAVES)); // R5
  AST_CLOSED_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    ended |-> !in_ready); // R7
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done && !out_valid); // R7

endmodule

// File: tb/test_tourney_sorter.sv
module test_tourney_sorter;
  localparam int N  = 16;
  localparam int KW = 16;
  localparam int PW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [KW-1:0] in_key = '0;
  logic [PW-1:0] in_ptr = '0;
  logic          in_last = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [KW-1:0] out_key;
  logic [PW-1:0] out_ptr;
  logic          out_first;
  logic          done;

  tourney_sorter #(.LEAVES(N), .KEY_W(KW), .PTR_W(PW)) i_tourney_sorter (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_key(in_key), .in_ptr(in_ptr), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_key(out_key), .out_ptr(out_ptr),
    .out_first(out_first), .done(done));

  always #4 clk = ~clk;

  int checks = 0, failures = 0;
  int exp_key[$], exp_ptr[$], exp_first[$];
  int sent_cnt = 0, out_cnt = 0, run_len = 0, cyc = 0;
  bit sent_last = 0, seen_any = 0;
  bit prev_stall = 0;
  int prev_key = 0, prev_ptr = 0, prev_first = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      out_ready = ((cyc % 5) != 2) && ((cyc % 7) != 3);
      if (rst_n) begin
        if (prev_stall)
          check(out_valid && int'(out_key) == prev_key && int'(out_ptr) == prev_ptr && int'(out_first) == prev_first,
                "R6", "held word key", int'(out_key), prev_key);
        if (out_valid && !sent_last && sent_cnt < N)
          check(0, "R2", "early output, keys in", sent_cnt, N);
        if (out_valid && out_ready) begin
          out_cnt++;
          if (exp_key.size() == 0) check(0, "R8", "extra word key", int'(out_key), -1);
          else begin
            int k, p, f;
            k = exp_key.pop_front(); p = exp_ptr.pop_front(); f = exp_first.pop_front();
            check(int'(out_key) == k, "R3", "key", int'(out_key), k);
            check(int'(out_ptr) == p, "R3", "pointer", int'(out_ptr), p);
            check(int'(out_first) == f, "R4", "first flag", int'(out_first), f);
          end
          if (out_first) begin
            if (seen_any) check(run_len >= N, "R5", "run length", run_len, N);
            run_len = 1; seen_any = 1;
          end else run_len++;
        end
        prev_stall = out_valid && !out_ready;
        prev_key = int'(out_key); prev_ptr = int'(out_ptr); prev_first = int'(out_first);
      end else prev_stall = 0;
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    sent_cnt = 0; out_cnt = 0; sent_last = 0; seen_any = 0; run_len = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid, "R1", "out_valid after reset", int'(out_valid), 0);
    check(in_ready, "R1", "in_ready after reset", int'(in_ready), 1);
    check(!done, "R1", "done after reset", int'(done), 0);
  endtask

  function automatic int key_of(input int kind, input int i, input int scen);
    case (kind)
      0: return (i * 157 + scen * 11) & 16'hFFFF;
      1: return 2000 - i * 3;
      2: return 100 + i * 2;
      default: return (i % 8) * 100 + i;
    endcase
  endfunction

  task automatic build_expected(input int n, input int kind, input int scen);
    int pk[$], pp[$], pr[$];
    int nxt = 0, last_run = -1, last_k = 0;
    while (nxt < n && pk.size() < N) begin
      pk.push_back(key_of(kind, nxt, scen)); pp.push_back((scen * 40 + nxt) & 8'hFF); pr.push_back(0);
      nxt++;
    end
    while (pk.size() > 0) begin
      int m = 0;
      for (int j = 1; j < pk.size(); j++)
        if (pr[j] < pr[m] || (pr[j] == pr[m] && pk[j] < pk[m])) m = j;
      exp_key.push_back(pk[m]); exp_ptr.push_back(pp[m]);
      exp_first.push_back(pr[m] != last_run ? 1 : 0);
      last_run = pr[m]; last_k = pk[m];
      pk.delete(m); pp.delete(m); pr.delete(m);
      if (nxt < n) begin
        int k = key_of(kind, nxt, scen);
        pk.push_back(k); pp.push_back((scen * 40 + nxt) & 8'hFF);
        pr.push_back(k < last_k ? last_run + 1 : last_run);
        nxt++;
      end
    end
  endtask

  task automatic run_case(input int n, input int kind, input int scen);
    do_reset();
    build_expected(n, kind, scen);
    for (int i = 0; i < n; i++) begin
      if (i == N - 1 && n > N) begin
        repeat (12) @(negedge clk);
        check(!out_valid, "R2", "output before tree filled", int'(out_valid), 0);
      end
      in_valid = 1'b1;
      in_key   = KW'(key_of(kind, i, scen));
      in_ptr   = PW'(scen * 40 + i);
      in_last  = (i == n - 1);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      sent_cnt++;
      if (i == n - 1) sent_last = 1;
    end
    repeat (2) @(negedge clk);
    check(!in_ready, "R7", "in_ready after last", int'(in_ready), 0);
    while (exp_key.size() > 0) @(negedge clk);
    repeat (10) @(negedge clk);
    check(done, "R7", "done after drain", int'(done), 1);
    check(!out_valid, "R7", "out_valid after done", int'(out_valid), 0);
    check(out_cnt == n, "R8", "words emitted", out_cnt, n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R7 watchdog: actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    run_case(48, 0, 1);
    run_case(40, 1, 2);
    run_case(36, 2, 3);
    run_case(40, 3, 4);
    run_case(5, 0, 5);
    run_case(N, 1, 6);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule